// File: doc/BRIEF.md
# Power-Key Debounce and Status Peripheral

This peripheral watches an active-low power-key line. It passes the line through a two-flop synchronizer and then through a debounce timer. The timer updates the clean key level only after the line has held a new value for a programmable time. That time is a power of two, from 1/64 s to 2 s, measured in ticks of a slow clock. The clean level, a pull-up enable and the debounce setting can be read and written through a byte-wide register port. The port decodes a 256-byte window that starts at a base address set by a parameter.

Each change of the clean level sets a sticky pending flag, whether the key was pressed or released. The interrupt output is this flag gated by an enable bit, so host software gets one event per press and one per release. The host reads the live level to tell the two apart, then clears the flag by writing 1 to it.

Top module: `pwrkey_monitor`

## Requirements
- R1: After reset the register at offset 0x10 reads 0x01, offset 0x70 reads 0x02, offset 0x71 reads 0x07, and offsets 0x15 and 0x18 read 0x00. `pullup_en` is 1 and `key_irq` is 0.
- R2: Offset 0x10 is read-only. Bit 0 holds the debounced level (1 = line high, key released; 0 = line low, key pressed), and bits 7:1 read 0.
- R3: When `key_n_raw` changes at a negative clock edge and then stays put, bit 0 of offset 0x10 takes the new value after exactly UNIT_CYCLES·2^N + 2 rising edges. N is the code in bits [2:0] of offset 0x71. This holds for each code 0 to 7.
- R4: A change of the raw line that returns to the debounced level before the delay has elapsed restarts the timer. It changes neither the debounced level nor the pending flag, and this holds for a short press and for a short release.
- R5: Bit 1 of offset 0x70 is the pull-up enable and drives `pullup_en` (1 = enabled). The other bits of that register are not stored and read 0.
- R6: Offset 0x71 stores the whole byte as written and reads it back unchanged. Only bits [2:0] select the debounce code.
- R7: Bit 0 of offset 0x18 is a pending flag. It is set on every change of the debounced level, both 1→0 and 0→1. Writing 1 to that bit clears the flag, and writing 0 leaves it unchanged.
- R8: Bit 0 of offset 0x15 is the interrupt enable. `key_irq` is 1 exactly when the pending flag and the enable are both 1, and clearing the enable hides a pending flag without clearing it.
- R9: Reads of unmapped offsets inside the window return 0x00, and writes to them have no effect. An address outside the window also reads 0x00, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow timer clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| key_n_raw | input | 1 | Raw active-low power-key line, asynchronous |
| reg_addr | input | ADDR_W | Register port byte address |
| reg_wr_en | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pullup_en | output | 1 | Pull-up enable for the key pad |
| key_irq | output | 1 | Key-change interrupt, level high |

## Verification
The assertions assume that the register port and the key line are driven away from the rising edge, and that reset is held for at least one rising edge before any other activity. They also assume a register write lasts one cycle with a stable address. In the bench every input changes only at a falling edge, and reset is held for several cycles at the start. A behavioural model in the bench follows the same inputs and is compared with the interrupt, the pull-up output and the read data after every rising edge. Separate directed checks time the settle interval for every code in both directions.

// File: rtl/pwrkey_pkg.sv
// Package: shared register offsets and widths for the power-key peripheral.
// Assumes byte-wide registers inside a 256-byte window.
package pwrkey_pkg;
    localparam int DATA_W = 8;
    localparam int WIN_W  = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [WIN_W-1:0]  offset_t;

    localparam offset_t OFF_LEVEL   = 8'h10;
    localparam offset_t OFF_IRQ_EN  = 8'h15;
    localparam offset_t OFF_PENDING = 8'h18;
    localparam offset_t OFF_PULL    = 8'h70;
    localparam offset_t OFF_DBNC    = 8'h71;

    localparam byte_t RST_PULL = 8'h02;
    localparam byte_t RST_DBNC = 8'h07;
endpackage

// File: rtl/pwrkey_sync.sv
// Module: multi-flop synchronizer for one asynchronous bit.
// Assumes the input may change at any time. Every stage resets to RESET_VAL.
module pwrkey_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the sampled bit one stage further on each edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[i] <= RESET_VAL;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrkey_debounce.sv
// Module: debounce timer. The output follows the input only after the input
// has differed from it for UNIT_CYCLES << code consecutive cycles.
// Assumes the input is already synchronous. The code is sampled live, so a
// code change also applies to a count in progress.
module pwrkey_debounce #(
    parameter int UNIT_CYCLES = 512,
    parameter int CODE_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_in,
    input  logic [CODE_W-1:0] code,
    output logic              level_out,
    output logic              flip
);
    localparam int MAX_LIMIT = UNIT_CYCLES << ((1 << CODE_W) - 1);
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             differ;

    // Work out the settle length for the selected code.
    always_comb begin
        limit = CNT_W'(UNIT_CYCLES) << code;
    end

    assign differ = (level_in != level_out);
    assign flip   = differ && (cnt >= limit - CNT_W'(1));

    // Count while the input differs; clear on a match or when the output flips.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!differ || flip) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Take the new level once it has settled; the reset state is released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_out <= 1'b1;
        end else if (flip) begin
            level_out <= level_in;
        end
    end
endmodule

// File: rtl/pwrkey_regs.sv
// Module: register window. Decodes a 256-byte window at BASE_ADDR, holds the
// control registers and the sticky pending flag.
// Assumes one write per cycle. Reads are combinational.
module pwrkey_regs
    import pwrkey_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0800,
    parameter int              CODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  byte_t             wdata,
    output byte_t             rdata,
    input  logic              level,
    input  logic              flip,
    output logic              pullup_en,
    output logic [CODE_W-1:0] dbnc_code,
    output logic              irq_en,
    output logic              pending
);
    logic    in_win;
    offset_t off;
    byte_t   dbnc_q;
    logic    wr_pull, wr_dbnc, wr_en_irq, wr_pend;

    assign in_win = (addr[ADDR_W-1:WIN_W] == BASE_ADDR[ADDR_W-1:WIN_W]);
    assign off    = addr[WIN_W-1:0];

    assign wr_pull   = wr_en && in_win && (off == OFF_PULL);
    assign wr_dbnc   = wr_en && in_win && (off == OFF_DBNC);
    assign wr_en_irq = wr_en && in_win && (off == OFF_IRQ_EN);
    assign wr_pend   = wr_en && in_win && (off == OFF_PENDING);

    // Pull-up enable bit; only bit 1 is stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pullup_en <= RST_PULL[1];
        end else if (wr_pull) begin
            pullup_en <= wdata[1];
        end
    end

    // Debounce control byte, kept whole for read-modify-write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbnc_q <= RST_DBNC;
        end else if (wr_dbnc) begin
            dbnc_q <= wdata;
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (wr_en_irq) begin
            irq_en <= wdata[0];
        end
    end

    // Sticky pending flag: a level change wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (flip) begin
            pending <= 1'b1;
        end else if (wr_pend && wdata[0]) begin
            pending <= 1'b0;
        end
    end

    assign dbnc_code = dbnc_q[CODE_W-1:0];

    // Read mux; unmapped offsets and foreign addresses read zero.
    always_comb begin
        rdata = '0;
        if (in_win) begin
            case (off)
                OFF_LEVEL:   rdata = {7'b0, level};
                OFF_IRQ_EN:  rdata = {7'b0, irq_en};
                OFF_PENDING: rdata = {7'b0, pending};
                OFF_PULL:    rdata = {6'b0, pullup_en, 1'b0};
                OFF_DBNC:    rdata = dbnc_q;
                default:     rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pwrkey_monitor.sv
// Module: top of the power-key peripheral. It chains the synchronizer, the
// debounce timer and the register window, and drives the interrupt.
// Assumes clk is the slow timer clock and that the key line is asynchronous.
module pwrkey_monitor
    import pwrkey_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h0800,
    parameter int                UNIT_CYCLES = 512,
    parameter int                CODE_W      = 3,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_n_raw,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              pullup_en,
    output logic              key_irq
);
    logic              key_sync;
    logic              level_db;
    logic              level_flip;
    logic [CODE_W-1:0] dbnc_code;
    logic              irq_en;
    logic              irq_pending;

    pwrkey_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (key_n_raw),
        .q     (key_sync)
    );

    pwrkey_debounce #(.UNIT_CYCLES(UNIT_CYCLES), .CODE_W(CODE_W)) u_dbnc (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (key_sync),
        .code      (dbnc_code),
        .level_out (level_db),
        .flip      (level_flip)
    );

    pwrkey_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CODE_W(CODE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .level     (level_db),
        .flip      (level_flip),
        .pullup_en (pullup_en),
        .dbnc_code (dbnc_code),
        .irq_en    (irq_en),
        .pending   (irq_pending)
    );

    assign key_irq = irq_pending & irq_en;
endmodule

// File: rtl/pwrkey_monitor_chk.sv
// Module: assertion checker bound to pwrkey_monitor.
// Assumes reset is held low for at least one rising edge at start-up.
module pwrkey_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic key_sync,
    input logic db_level,
    input logic pending,
    input logic irq_en,
    input logic irq,
    input logic pullup_en
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (db_level && !pending && pullup_en && !irq)); // R1

    AST_FLIP_TAKES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (db_level != $past(db_level)) |-> (db_level == $past(key_sync))); // R3

    AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_sync == db_level) |=> $stable(db_level)); // R4

    AST_EDGE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (db_level != $past(db_level)) |-> pending); // R7

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && pending)); // R8
endmodule

bind pwrkey_monitor pwrkey_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_sync  (key_sync),
    .db_level  (level_db),
    .pending   (irq_pending),
    .irq_en    (irq_en),
    .irq       (key_irq),
    .pullup_en (pullup_en)
);

// File: tb/tb_pwrkey_monitor.sv
`timescale 1ns/1ps
module tb_pwrkey_monitor;
    localparam int          UNIT = 8;
    localparam logic [15:0] BASE = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_n = 1'b1;
    logic [15:0] addr = BASE;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        pullup_en, key_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    pwrkey_monitor #(.ADDR_W(16), .BASE_ADDR(BASE), .UNIT_CYCLES(UNIT)) dut (
        .clk(clk), .rst_n(rst_n), .key_n_raw(key_n), .reg_addr(addr),
        .reg_wr_en(wr), .reg_wdata(wdata), .reg_rdata(rdata),
        .pullup_en(pullup_en), .key_irq(key_irq)
    );

    // Behavioural reference: a two-entry sample queue, a settle counter, registers.
    bit   m_pipe[$];
    bit   m_db;
    int   m_cnt;
    bit   m_pend, m_en, m_pull;
    logic [7:0] m_dbnc;

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (a[15:8] != BASE[15:8]) return 8'h00;
        case (a[7:0])
            8'h10: return {7'b0, m_db};
            8'h15: return {7'b0, m_en};
            8'h18: return {7'b0, m_pend};
            8'h70: return {6'b0, m_pull, 1'b0};
            8'h71: return m_dbnc;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pipe = '{1'b1, 1'b1};
            m_db = 1; m_cnt = 0; m_pend = 0; m_en = 0; m_pull = 1; m_dbnc = 8'h07;
        end else begin
            bit synced, settle;
            int need;
            synced = m_pipe[0];
            need = UNIT << m_dbnc[2:0];
            settle = (synced != m_db) && (m_cnt + 1 >= need);
            if (synced == m_db || settle) m_cnt = 0; else m_cnt = m_cnt + 1;
            if (settle) m_db = synced;
            if (settle) m_pend = 1;
            else if (wr && addr == BASE + 16'h18 && wdata[0]) m_pend = 0;
            if (wr && addr == BASE + 16'h15) m_en = wdata[0];
            if (wr && addr == BASE + 16'h70) m_pull = wdata[1];
            if (wr && addr == BASE + 16'h71) m_dbnc = wdata;
            void'(m_pipe.pop_front());
            m_pipe.push_back(key_n);
        end
    end

    // Compare the design with the model shortly after every rising edge.
    always @(posedge clk) begin
        #2;
        if (cmp_on && rst_n) begin
            total++;
            if (key_irq !== (m_pend && m_en) || pullup_en !== m_pull || rdata !== m_read(addr)) begin
                bad++;
                $display("FAIL R3/R7/R8 model: irq=%0b pull=%0b rdata=%02h exp irq=%0b pull=%0b rdata=%02h",
                         key_irq, pullup_en, rdata, m_pend && m_en, m_pull, m_read(addr));
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle_time(input bit lvl, output int n);
        @(negedge clk);
        addr = BASE + 16'h10;
        key_n = lvl;
        n = 0;
        do begin
            @(posedge clk);
            #1 n++;
        end while (rdata[0] !== lvl && n < 3000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;

        // R1 reset values
        rd_reg(BASE + 16'h10, v); check("R1 level", v, 8'h01);
        rd_reg(BASE + 16'h70, v); check("R1 pull", v, 8'h02);
        rd_reg(BASE + 16'h71, v); check("R1 dbnc", v, 8'h07);
        rd_reg(BASE + 16'h15, v); check("R1 irq_en", v, 8'h00);
        rd_reg(BASE + 16'h18, v); check("R1 pending", v, 8'h00);
        check("R1 pullup_en", pullup_en, 1);
        check("R1 key_irq", key_irq, 0);

        // R5 pull-up bit
        wr_reg(BASE + 16'h70, 8'hFF);
        rd_reg(BASE + 16'h70, v); check("R5 pull only bit1", v, 8'h02);
        wr_reg(BASE + 16'h70, 8'h00);
        rd_reg(BASE + 16'h70, v); check("R5 pull off", v, 8'h00);
        check("R5 pullup_en off", pullup_en, 0);
        wr_reg(BASE + 16'h70, 8'h02);
        check("R5 pullup_en on", pullup_en, 1);

        // R6 whole byte stored
        wr_reg(BASE + 16'h71, 8'hA8);
        rd_reg(BASE + 16'h71, v); check("R6 dbnc readback", v, 8'hA8);

        // R9 unmapped and foreign addresses
        wr_reg(BASE + 16'h20, 8'h55);
        rd_reg(BASE + 16'h20, v); check("R9 unmapped read", v, 8'h00);
        wr_reg(16'h0971, 8'h33);
        rd_reg(16'h0971, v); check("R9 foreign read", v, 8'h00);
        rd_reg(BASE + 16'h71, v); check("R9 foreign write ignored", v, 8'hA8);
        wr_reg(BASE + 16'h10, 8'h00);
        rd_reg(BASE + 16'h10, v); check("R2 level read-only", v, 8'h01);

        wr_reg(BASE + 16'h15, 8'h01);

        // R3 settle time for every code, press and release; R7 both edges
        for (int c = 0; c < 8; c++) begin
            wr_reg(BASE + 16'h71, 8'hF0 | 8'(c));
            settle_time(1'b0, n);
            check($sformatf("R3 press code %0d", c), n, (UNIT << c) + 2);
            rd_reg(BASE + 16'h10, v); check("R2 pressed reads 0", v, 8'h00);
            check("R7 pending on press", key_irq, 1);
            wr_reg(BASE + 16'h18, 8'h01);
            check("R7 cleared", key_irq, 0);
            settle_time(1'b1, n);
            check($sformatf("R3 release code %0d", c), n, (UNIT << c) + 2);
            check("R7 pending on release", key_irq, 1);
            wr_reg(BASE + 16'h18, 8'h01);
        end

        // R4 short press and short release glitches
        wr_reg(BASE + 16'h71, 8'h03);
        @(negedge clk); key_n = 1'b0;
        repeat (40) @(negedge clk);
        key_n = 1'b1;
        repeat (200) @(negedge clk);
        rd_reg(BASE + 16'h10, v); check("R4 press glitch level", v, 8'h01);
        rd_reg(BASE + 16'h18, v); check("R4 press glitch pending", v, 8'h00);
        check("R4 press glitch irq", key_irq, 0);
        settle_time(1'b0, n);
        wr_reg(BASE + 16'h18, 8'h01);
        @(negedge clk); key_n = 1'b1;
        repeat (40) @(negedge clk);
        key_n = 1'b0;
        repeat (200) @(negedge clk);
        rd_reg(BASE + 16'h10, v); check("R4 release glitch level", v, 8'h00);
        rd_reg(BASE + 16'h18, v); check("R4 release glitch pending", v, 8'h00);

        // R7 write 0 keeps flag; R8 enable gating
        settle_time(1'b1, n);
        wr_reg(BASE + 16'h18, 8'h00);
        rd_reg(BASE + 16'h18, v); check("R7 write0 no clear", v, 8'h01);
        wr_reg(BASE + 16'h15, 8'h00);
        check("R8 irq masked", key_irq, 0);
        rd_reg(BASE + 16'h18, v); check("R8 pending kept", v, 8'h01);
        wr_reg(BASE + 16'h15, 8'h01);
        check("R8 irq unmasked", key_irq, 1);

        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule